// File: doc/BRIEF.md
# Fractional-N Modulus Sequence Generator

This block is the digital control for a fractional-N frequency divider. Each time the divided clock produces an event, the block returns one integer division value for the integer N divider. Over a long run these values average to INT + FRAC/2^M, where M is the width of the fractional word (25 bits by default). A wide fixed modulus gives very fine frequency steps while the integer divider only ever sees whole numbers.

Two ways of choosing the value can be selected per event. In dither mode a maximal-length shift register produces a new pseudorandom word at each event. The value is INT + 1 when that word is below FRAC and INT otherwise. In noise-shaped mode a three-stage cascade of accumulators (MASH 1-1-1) forms a correction in the range −3 to +4. That correction pushes the quantisation error toward high offset frequencies and leaves no fixed tones for a constant fraction.

All state moves only when the event strobe is high. The new value is registered and appears on the output one clock after the strobe.

Top module: `fracn_modsel`

## Requirements
- R1: After reset the output `divVal` is 0, the pseudorandom register holds the nonzero parameter `SEED` (default 1), and all accumulators and carry history are zero.
- R2: `divVal` changes only on the clock edge at which `evtStb` is 1, and it holds the value computed at that edge until the next such edge.
- R3: In dither mode (`modeSel` = 0) with FRAC nonzero, the value is INT + 1 when the current pseudorandom word, read as unsigned, is less than FRAC. Otherwise the value is INT.
- R4: The pseudorandom register (M bits) steps once per event, in both modes, by the rule s' = {s[M-2:0], s[M-1] ^ s[M-4]}, which is the polynomial x^25 + x^22 + 1 at M = 25. It never reaches zero.
- R5: The noise-shaped cascade works modulo 2^M at each event: a1' = a1 + FRAC, a2' = a2 + a1', a3' = a3 + a2'. The carries out of these three sums are c1, c2 and c3.
- R6: In noise-shaped mode (`modeSel` = 1) with FRAC nonzero, the value is INT + c1 + (c2 − c2p) + (c3 − 2·c3p + c3pp). Here c2p is c2 of the previous event, and c3p and c3pp are c3 of the previous event and of the event before that. The value therefore always lies between INT − 3 and INT + 4.
- R7: When FRAC is 0 at an event, the value is exactly INT in either mode, and the accumulators and carry history are cleared to zero.
- R8: Both engines advance at every event whatever the mode, and `modeSel` is sampled at the event, so the mode can change between any two events.
- R9: INT, FRAC and the mode are sampled only at an event. A change between events has no effect until the next event.
- R10: In noise-shaped mode, starting from cleared state with constant FRAC = 2^(M-2), the sum of (value − INT) over 64 events lies within 16 ± 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evtStb | input | 1 | Divider-event strobe, one cycle per divided-clock event |
| modeSel | input | 1 | 0 selects pseudorandom dither, 1 selects the noise-shaped cascade |
| intVal | input | INT_W (16) | Integer part INT of the division ratio |
| fracVal | input | FRAC_W (25) | Fractional word FRAC, in units of 2^-FRAC_W |
| divVal | output | INT_W (16) | Division value for the integer divider, registered |

## Verification
A corrupt pseudorandom state shows up at the ports on the first dither event whose FRAC falls between the true word and the corrupt one. Random FRAC values therefore expose it within a few events of a per-event model comparison. A wrong accumulator or carry history changes the noise-shaped correction no later than the third event after the fault, because the second-difference term reaches back two events. A history that is not cleared when FRAC is zero shows as a value other than INT on a zero-fraction event or on the events that follow it. The 64-event sum catches errors in the long-run average that stay inside the legal −3..+4 range.

// File: rtl/fracn_pkg.sv
package fracn_pkg;

  // Strobes the control half hands to the datapath at each clock.
  typedef struct packed {
    logic advance;   // divider event: register a value, step engines
    logic selMash;   // pick the noise-shaped correction
    logic fracZero;  // fraction is zero: force INT, clear cascade
  } fracnStrb_t;

  localparam int MASH_STAGES = 3;
  localparam int CORR_W      = 4;  // signed, holds -3..+4

endpackage

// File: rtl/fracn_ctrl.sv
module fracn_ctrl
  import fracn_pkg::*;
#(
  parameter int FRAC_W = 25
) (
  input  logic              evtStb,
  input  logic              modeSel,
  input  logic [FRAC_W-1:0] fracVal,
  output fracnStrb_t        strb
);

  always_comb begin
    strb.advance  = evtStb;
    strb.selMash  = modeSel;
    strb.fracZero = (fracVal == '0);
  end

endmodule

// File: rtl/fracn_lfsr.sv
module fracn_lfsr #(
  parameter int          W     = 25,
  parameter int          TAP_A = W - 1,
  parameter int          TAP_B = W - 4,
  parameter logic [W-1:0] SEED = 1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         advance,
  output logic [W-1:0] state
);

  logic feedBit;
  assign feedBit = state[TAP_A] ^ state[TAP_B];

  always_ff @(posedge clk) begin
    if (!rstN)        state <= SEED;
    else if (advance) state <= {state[W-2:0], feedBit};
  end

  // R4
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    state != '0);

  // R4
  lfsr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !advance |=> $stable(state));

endmodule

// File: rtl/fracn_mash.sv
module fracn_mash
  import fracn_pkg::*;
#(
  parameter int W = 25
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     advance,
  input  logic                     clear,
  input  logic [W-1:0]             fracVal,
  output logic signed [CORR_W-1:0] corr
);

  localparam int S = MASH_STAGES;

  logic [S-1:0][W-1:0] acc;
  logic [S-1:0][W:0]   sum;
  logic [S-1:0]        carry;
  logic                c2Prev, c3Prev, c3Prev2;

  for (genvar g = 0; g < S; g++) begin : g_stage
    if (g == 0) begin : g_head
      assign sum[g] = {1'b0, acc[g]} + {1'b0, fracVal};
    end else begin : g_tail
      assign sum[g] = {1'b0, acc[g]} + {1'b0, sum[g-1][W-1:0]};
    end
    assign carry[g] = sum[g][W];

    always_ff @(posedge clk) begin
      if (!rstN)        acc[g] <= '0;
      else if (advance) acc[g] <= clear ? '0 : sum[g][W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      c2Prev  <= 1'b0;
      c3Prev  <= 1'b0;
      c3Prev2 <= 1'b0;
    end else if (advance) begin
      c2Prev  <= clear ? 1'b0 : carry[1];
      c3Prev  <= clear ? 1'b0 : carry[2];
      c3Prev2 <= clear ? 1'b0 : c3Prev;
    end
  end

  always_comb begin
    corr = $signed({3'b000, carry[0]})
         + $signed({3'b000, carry[1]}) - $signed({3'b000, c2Prev})
         + $signed({3'b000, carry[2]}) - $signed({2'b00, c3Prev, 1'b0})
         + $signed({3'b000, c3Prev2});
  end

  // R7
  mash_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (advance && clear) |=> (acc == '0 && !c2Prev && !c3Prev && !c3Prev2));

  // R5
  mash_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !advance |=> $stable(acc));

endmodule

// File: rtl/fracn_dp.sv
module fracn_dp
  import fracn_pkg::*;
#(
  parameter int              INT_W  = 16,
  parameter int              FRAC_W = 25,
  parameter logic [FRAC_W-1:0] SEED = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  fracnStrb_t        strb,
  input  logic [INT_W-1:0]  intVal,
  input  logic [FRAC_W-1:0] fracVal,
  output logic [INT_W-1:0]  divVal
);

  logic [FRAC_W-1:0]        lfsrWord;
  logic signed [CORR_W-1:0] mashCorr;
  logic [INT_W-1:0]         nextVal;
  logic                     ditherUp;

  fracn_lfsr #(.W(FRAC_W), .SEED(SEED)) u_lfsr (
    .clk     (clk),
    .rstN    (rstN),
    .advance (strb.advance),
    .state   (lfsrWord)
  );

  fracn_mash #(.W(FRAC_W)) u_mash (
    .clk     (clk),
    .rstN    (rstN),
    .advance (strb.advance),
    .clear   (strb.fracZero),
    .fracVal (fracVal),
    .corr    (mashCorr)
  );

  assign ditherUp = (lfsrWord < fracVal);

  always_comb begin
    if (strb.fracZero)     nextVal = intVal;
    else if (strb.selMash) nextVal = intVal + {{(INT_W-CORR_W){mashCorr[CORR_W-1]}}, mashCorr};
    else                   nextVal = intVal + {{(INT_W-1){1'b0}}, ditherUp};
  end

  always_ff @(posedge clk) begin
    if (!rstN)              divVal <= '0;
    else if (strb.advance)  divVal <= nextVal;
  end

  // R2
  out_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.advance |=> $stable(divVal));

  // R3
  dither_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.advance && !strb.selMash && !strb.fracZero) |=>
      (divVal == $past(intVal) || divVal == $past(intVal) + 1'b1));

  // R6
  mash_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.advance && strb.selMash && !strb.fracZero) |=>
      ($signed(divVal - $past(intVal)) >= -3 && $signed(divVal - $past(intVal)) <= 4));

  // R7
  frac_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.advance && strb.fracZero) |=> divVal == $past(intVal));

endmodule

// File: rtl/fracn_modsel.sv
module fracn_modsel
  import fracn_pkg::*;
#(
  parameter int                INT_W  = 16,
  parameter int                FRAC_W = 25,
  parameter logic [FRAC_W-1:0] SEED   = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              evtStb,
  input  logic              modeSel,
  input  logic [INT_W-1:0]  intVal,
  input  logic [FRAC_W-1:0] fracVal,
  output logic [INT_W-1:0]  divVal
);

  fracnStrb_t strb;

  fracn_ctrl #(.FRAC_W(FRAC_W)) u_ctrl (
    .evtStb  (evtStb),
    .modeSel (modeSel),
    .fracVal (fracVal),
    .strb    (strb)
  );

  fracn_dp #(.INT_W(INT_W), .FRAC_W(FRAC_W), .SEED(SEED)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .intVal  (intVal),
    .fracVal (fracVal),
    .divVal  (divVal)
  );

endmodule

// File: tb/sim_fracn_modsel.sv
module sim_fracn_modsel;

  localparam int IW = 16;
  localparam int FW = 25;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          evtStb = 1'b0;
  logic          modeSel = 1'b0;
  logic [IW-1:0] intVal = 16'd100;
  logic [FW-1:0] fracVal = '0;
  logic [IW-1:0] divVal;

  int  errors = 0;
  int  checks = 0;
  bit  done = 0;

  // bench reference state
  logic [FW-1:0] mLfsr;
  logic [FW-1:0] mA1, mA2, mA3;
  bit            mC2p, mC3p, mC3pp;

  always #5 clk = ~clk;

  fracn_modsel u0 (
    .clk(clk), .rstN(rstN), .evtStb(evtStb), .modeSel(modeSel),
    .intVal(intVal), .fracVal(fracVal), .divVal(divVal)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [FW-1:0] lfsrStep(input logic [FW-1:0] s);
    return {s[FW-2:0], s[FW-1] ^ s[FW-4]};
  endfunction

  // Expected value per R3, R5, R6, R7; advances reference per R4, R8.
  task automatic modelStep(input logic [FW-1:0] f, input bit m,
                           input logic [IW-1:0] iv, output logic [IW-1:0] e);
    logic [FW:0] s1, s2, s3;
    int corr;
    s1 = {1'b0, mA1} + {1'b0, f};
    s2 = {1'b0, mA2} + {1'b0, s1[FW-1:0]};
    s3 = {1'b0, mA3} + {1'b0, s2[FW-1:0]};
    corr = int'(s1[FW]) + int'(s2[FW]) - int'(mC2p) + int'(s3[FW])
         - 2 * int'(mC3p) + int'(mC3pp);
    if (f == '0)  e = iv;
    else if (m)   e = IW'(int'(iv) + corr);
    else          e = iv + ((mLfsr < f) ? 16'd1 : 16'd0);
    mLfsr = lfsrStep(mLfsr);
    if (f == '0) begin
      mA1 = '0; mA2 = '0; mA3 = '0; mC2p = 0; mC3p = 0; mC3pp = 0;
    end else begin
      mA1 = s1[FW-1:0]; mA2 = s2[FW-1:0]; mA3 = s3[FW-1:0];
      mC3pp = mC3p; mC3p = s3[FW]; mC2p = s2[FW];
    end
  endtask

  task automatic doEvent(input logic [FW-1:0] f, input bit m,
                         input logic [IW-1:0] iv, input string tag);
    logic [IW-1:0] e;
    @(negedge clk);
    fracVal = f; modeSel = m; intVal = iv; evtStb = 1'b1;
    modelStep(f, m, iv, e);
    @(negedge clk);
    evtStb = 1'b0;
    chk(divVal == e, tag, int'(divVal), int'(e));
  endtask

  initial begin
    int seedDummy;
    logic [IW-1:0] held;
    int acc;
    seedDummy = $urandom(32'd20251);
    mLfsr = 25'd1; mA1 = '0; mA2 = '0; mA3 = '0;
    mC2p = 0; mC3p = 0; mC3pp = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(divVal == 16'd0, "R1 reset output", int'(divVal), 0);
    // R1 R3: first dither event sees seed word 1
    doEvent(25'd5, 1'b0, 16'd200, "R1 R3 seed dither");
    chk(divVal == 16'd201, "R1 seed word below FRAC", int'(divVal), 201);

    // R2 R9: inputs change without strobe, output holds
    held = divVal;
    @(negedge clk);
    fracVal = 25'h1FFFFFF; intVal = 16'd999; modeSel = 1'b1;
    repeat (4) @(negedge clk);
    chk(divVal == held, "R2 R9 hold between events", int'(divVal), int'(held));

    // R7: zero fraction in both modes
    doEvent(25'd0, 1'b0, 16'd321, "R7 zero frac dither");
    doEvent(25'd0, 1'b1, 16'd322, "R7 zero frac mash");
    chk(divVal == 16'd322, "R7 exact INT", int'(divVal), 322);

    // R3: largest fraction in dither mode
    for (int i = 0; i < 8; i++) doEvent(25'h1FFFFFF, 1'b0, 16'd3000, "R3 max frac dither");

    // R6: largest fraction in mash mode
    for (int i = 0; i < 8; i++) doEvent(25'h1FFFFFF, 1'b1, 16'd3, "R6 max frac mash");

    // R10: average over 64 events from cleared state
    doEvent(25'd0, 1'b1, 16'd500, "R7 clear before average");
    acc = 0;
    for (int i = 0; i < 64; i++) begin
      doEvent(25'h0800000, 1'b1, 16'd500, "R5 R6 quarter frac");
      acc += int'(divVal) - 500;
    end
    chk(acc >= 13 && acc <= 19, "R10 average", acc, 16);

    // R4 R5 R6 R8: random mix with mode switching and idle gaps
    for (int i = 0; i < 600; i++) begin
      logic [FW-1:0] f;
      bit m;
      logic [IW-1:0] iv;
      f  = FW'($urandom);
      if ($urandom_range(0, 15) == 0) f = '0;
      m  = 1'($urandom_range(0, 1));
      iv = IW'($urandom_range(3, 60000));
      doEvent(f, m, iv, m ? "R4 R6 R8 random mash" : "R4 R3 R8 random dither");
      if ($urandom_range(0, 3) == 0) begin
        held = divVal;
        fracVal = FW'($urandom);
        repeat ($urandom_range(1, 3)) @(negedge clk);
        chk(divVal == held, "R2 R9 random gap hold", int'(divVal), int'(held));
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule